// File: doc/BRIEF.md
# Streaming NAND ECC Parity Generator

This block sits on the byte path between a host and a NAND flash device and builds Hamming-style parity on the fly while page data streams past. Each chunk of data bytes (256 by default) produces two parity words of 11 bits. Every data bit is addressed by a combined index: its bit position inside the byte in the low bits, and the byte's offset inside the chunk above that. The first word is the parity over all bits whose address has a one at a given position. The second word is the parity over all bits whose address has a zero there.

A mode input picks between a one-chunk unit and a two-chunk unit of 512 bytes. The second chunk fills its own pair of words. The words are presented directly, and also packed into a 3-byte code per chunk. A synchronous clear, issued before each page, empties the accumulators and rewinds the byte counter. A one-cycle pulse marks each chunk whose parity is final. After the last byte of the unit the words hold still and further bytes are ignored until the next clear. Error correction and the flash pin interface are handled elsewhere.

Top module: `ecc_parity_gen`

## Requirements
- R1: For chunk c, `par_a[c]` bit k is the XOR of every data bit whose 11-bit address has bit k set. The address is {byte offset within chunk[7:0], bit position[2:0]}, so bits 2:0 come from the bit position and bits 10:3 from the byte offset.
- R2: `par_b[c]` bit k is the XOR of every data bit whose 11-bit address has bit k clear.
- R3: `code[c]` is the 24-bit value {2'b00, par_b[c], par_a[c]}, with `par_a` in bits 10:0 and `par_b` in bits 21:11. Byte 0 of the code is bits 7:0.
- R4: With `big_page`=1, bytes 0..255 of the unit accumulate into chunk 0 and bytes 256..511 into chunk 1.
- R5: With `big_page`=0, only chunk 0 accumulates, chunk 1 stays zero, and bytes after the 256th are ignored.
- R6: With `big_page`=1, bytes after the 512th are ignored and all words keep their values.
- R7: `clr` high at a clock edge zeroes all words, the byte counter and `chunk_done`. It takes priority over `din_valid` in the same cycle.
- R8: A cycle with `din_valid` low changes neither the words nor the byte counter.
- R9: `chunk_done` is high for exactly one cycle, in the cycle after the last byte of a chunk is accepted, and the words are final in that same cycle.
- R10: A chunk of 256 bytes that are all 0xFF produces an all-zero code.
- R11: After reset every word and code is zero and `chunk_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous per-page clear of words and counter |
| big_page | input | 1 | 1: two-chunk unit, 0: single chunk |
| din_valid | input | 1 | Data byte strobe |
| din | input | 8 | Data byte |
| par_a | output | 2x11 | First parity word per chunk |
| par_b | output | 2x11 | Complement parity word per chunk |
| code | output | 2x24 | Packed 3-byte code per chunk |
| chunk_done | output | 1 | One-cycle pulse when a chunk's parity is final |

## Verification
The bench goes after the address split. It uses a single set bit at a known byte and bit, where a design that swapped the bit-position and byte-offset fields, or merged the two words, would give a wrong literal code. It overruns the unit in both modes and interleaves idle cycles carrying garbage. A counter that failed to saturate or that ignored the strobe would then corrupt chunk 0 or leak into chunk 1. It also checks erased-chunk data, a clear issued together with a valid byte, and the exact cycle of each done pulse. An off-by-one counter would show up as a pulse at the wrong byte count or a second pulse in 256-byte mode.

// File: rtl/ecc_par_pkg.sv
package ecc_par_pkg;
   // chunk activity as seen by the sequencer
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FULL  = 2'd1
   } seq_state_e;

   // number of chunks active for a mode setting
   function automatic int unsigned active_chunks(input logic big, input int unsigned n_max);
      return big ? n_max : 1;
   endfunction
endpackage

// File: rtl/ecc_byte_terms.sv
module ecc_byte_terms #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 8,
   localparam int BP_W  = $clog2(DATA_W),
   localparam int PW    = BP_W + IDX_W
) (
   input  logic [DATA_W-1:0] data,
   input  logic [IDX_W-1:0]  idx,
   output logic [PW-1:0]     term_a,
   output logic [PW-1:0]     term_b
);
   logic row_par;

   always_comb begin
      row_par = ^data;
      term_a  = '0;
      term_b  = '0;
      // bit-position part of the address
      for (int k = 0; k < BP_W; k++) begin
         for (int b = 0; b < DATA_W; b++) begin
            if (((b >> k) & 1) == 1) term_a[k] = term_a[k] ^ data[b];
            else                     term_b[k] = term_b[k] ^ data[b];
         end
      end
      // byte-offset part: whole-byte parity steered by the offset bits
      for (int j = 0; j < IDX_W; j++) begin
         term_a[BP_W+j] = row_par &  idx[j];
         term_b[BP_W+j] = row_par & ~idx[j];
      end
   end
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
   parameter int PW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [PW-1:0] term_a,
   input  logic [PW-1:0] term_b,
   output logic [PW-1:0] acc_a,
   output logic [PW-1:0] acc_b
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_a <= '0;
         acc_b <= '0;
      end else if (clr) begin
         acc_a <= '0;
         acc_b <= '0;
      end else if (en) begin
         acc_a <= acc_a ^ term_a;
         acc_b <= acc_b ^ term_b;
      end
   end
endmodule

// File: rtl/ecc_seq.sv
module ecc_seq
   import ecc_par_pkg::*;
#(
   parameter int CHUNK_BYTES = 256,
   parameter int NUM_CHUNKS  = 2,
   localparam int IDX_W      = $clog2(CHUNK_BYTES),
   localparam int SEL_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
   localparam int CNT_W      = IDX_W + SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             big_page,
   input  logic             din_valid,
   output logic             take,
   output logic [IDX_W-1:0] idx,
   output logic [SEL_W-1:0] sel,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST_BIG   = CNT_W'(NUM_CHUNKS*CHUNK_BYTES - 1);
   localparam logic [CNT_W-1:0] LAST_SMALL = CNT_W'(CHUNK_BYTES - 1);
   localparam logic [IDX_W-1:0] IDX_END    = IDX_W'(CHUNK_BYTES - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   seq_state_e       st;

   assign last = big_page ? LAST_BIG : LAST_SMALL;
   assign take = din_valid & ~clr & (st != SEQ_FULL);
   assign idx  = cnt[IDX_W-1:0];
   assign sel  = cnt[CNT_W-1:IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         st   <= SEQ_IDLE;
         done <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         st   <= SEQ_IDLE;
         done <= 1'b0;
      end else begin
         done <= take && (idx == IDX_END);
         if (take) begin
            if (cnt >= last) st  <= SEQ_FULL;
            else             cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ecc_parity_gen.sv
module ecc_parity_gen #(
   parameter int DATA_W      = 8,
   parameter int CHUNK_BYTES = 256,
   parameter int NUM_CHUNKS  = 2,
   localparam int BP_W       = $clog2(DATA_W),
   localparam int IDX_W      = $clog2(CHUNK_BYTES),
   localparam int PW         = BP_W + IDX_W,
   localparam int CODE_W     = ((2*PW + 7) / 8) * 8,
   localparam int SEL_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             big_page,
   input  logic                             din_valid,
   input  logic [DATA_W-1:0]                din,
   output logic [NUM_CHUNKS-1:0][PW-1:0]    par_a,
   output logic [NUM_CHUNKS-1:0][PW-1:0]    par_b,
   output logic [NUM_CHUNKS-1:0][CODE_W-1:0] code,
   output logic                             chunk_done
);
   initial begin
      if ((1 << BP_W) != DATA_W)      $error("DATA_W must be a power of two");
      if ((1 << IDX_W) != CHUNK_BYTES) $error("CHUNK_BYTES must be a power of two");
      if ((1 << SEL_W) < NUM_CHUNKS)   $error("NUM_CHUNKS out of range");
   end

   logic             take;
   logic [IDX_W-1:0] idx;
   logic [SEL_W-1:0] sel;
   logic [PW-1:0]    term_a, term_b;

   ecc_seq #(.CHUNK_BYTES(CHUNK_BYTES), .NUM_CHUNKS(NUM_CHUNKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .big_page(big_page),
      .din_valid(din_valid), .take(take), .idx(idx), .sel(sel), .done(chunk_done)
   );

   ecc_byte_terms #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_terms (
      .data(din), .idx(idx), .term_a(term_a), .term_b(term_b)
   );

   for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
      logic          en_c;
      logic [PW-1:0] acc_a, acc_b;
      assign en_c = take && (sel == SEL_W'(c));
      ecc_accum #(.PW(PW)) u_acc (
         .clk(clk), .rst_n(rst_n), .clr(clr), .en(en_c),
         .term_a(term_a), .term_b(term_b), .acc_a(acc_a), .acc_b(acc_b)
      );
      assign par_a[c] = acc_a;
      assign par_b[c] = acc_b;
      assign code[c]  = CODE_W'({acc_b, acc_a});
   end
endmodule

// File: rtl/ecc_par_checker.sv
module ecc_par_checker #(
   parameter int PW         = 11,
   parameter int NUM_CHUNKS = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          clr,
   input logic                          din_valid,
   input logic                          chunk_done,
   input logic [NUM_CHUNKS-1:0][PW-1:0] par_a,
   input logic [NUM_CHUNKS-1:0][PW-1:0] par_b
);
   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (par_a == '0) && (par_b == '0) && !chunk_done);

   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!din_valid && !clr) |=> $stable(par_a) && $stable(par_b));

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_done |=> !chunk_done);

   a_r9_pulse_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chunk_done) |-> $past(din_valid) && !$past(clr));
endmodule

bind ecc_parity_gen ecc_par_checker #(.PW(PW), .NUM_CHUNKS(NUM_CHUNKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .din_valid(din_valid),
   .chunk_done(chunk_done), .par_a(par_a), .par_b(par_b)
);

// File: tb/sim_ecc_parity_gen.sv
`timescale 1ns/1ps
module sim_ecc_parity_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic big_page = 1'b0;
   logic din_valid = 1'b0;
   logic [7:0] din = '0;
   logic [1:0][10:0] par_a, par_b;
   logic [1:0][23:0] code;
   logic chunk_done;

   int n_chk = 0;
   int n_bad = 0;
   int nd, d1, d2;
   bit finished = 0;
   logic [7:0] mem [512];

   always #2.5 clk = ~clk;

   ecc_parity_gen u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .big_page(big_page),
      .din_valid(din_valid), .din(din), .par_a(par_a), .par_b(par_b),
      .code(code), .chunk_done(chunk_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [21:0] ref_pair(input int base);
      logic [10:0] p, q, a;
      p = '0; q = '0;
      for (int i = 0; i < 256; i++)
         for (int b = 0; b < 8; b++)
            if (mem[base+i][b]) begin
               a = {8'(i), 3'(b)};
               p ^= a;
               q ^= ~a;
            end
      return {q, p};
   endfunction

   task automatic note(input int k);
      if (chunk_done) begin
         nd++;
         if (nd == 1) d1 = k; else d2 = k;
      end
   endtask

   task automatic feed(input int n, input bit gap);
      nd = 0; d1 = -1; d2 = -1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); note(i);
         din = mem[i]; din_valid = 1'b1;
         if (gap) begin
            @(negedge clk); note(i + 1);
            din = ~mem[i]; din_valid = 1'b0;
         end
      end
      @(negedge clk); note(n); din_valid = 1'b0;
      @(negedge clk); note(n);
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1; din_valid = 1'b1; din = 8'hA7;
      @(negedge clk); clr = 1'b0; din_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 par_a0", 32'(par_a[0]), 0);
      chk("R11 par_b1", 32'(par_b[1]), 0);
      chk("R11 code0", 32'(code[0]), 0);
      chk("R11 done", 32'(chunk_done), 0);
   endtask

   task automatic t_erased();
      do_clear(); big_page = 1'b0;
      for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
      feed(256, 0);
      chk("R10 erased code0", 32'(code[0]), 0);
      chk("R9 done count small", nd, 1);
      chk("R9 done at byte 256", d1, 256);
   endtask

   task automatic t_single();
      do_clear(); big_page = 1'b0;
      for (int i = 0; i < 512; i++) mem[i] = 8'h00;
      mem[8'h5A] = 8'h08;
      feed(256, 0);
      chk("R1 single bit par_a", 32'(par_a[0]), 32'h2D3);
      chk("R2 single bit par_b", 32'(par_b[0]), 32'h52C);
      chk("R3 packed code", 32'(code[0]), 32'h2962D3);
      chk("R3 code byte0", 32'(code[0][7:0]), 32'hD3);
   endtask

   task automatic t_big();
      logic [21:0] r0, r1;
      do_clear(); big_page = 1'b1;
      for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + (i >> 3)) ^ 8'h3C);
      r0 = ref_pair(0); r1 = ref_pair(256);
      feed(512, 0);
      chk("R4 chunk0 par_a", 32'(par_a[0]), 32'(r0[10:0]));
      chk("R4 chunk0 par_b", 32'(par_b[0]), 32'(r0[21:11]));
      chk("R4 chunk1 par_a", 32'(par_a[1]), 32'(r1[10:0]));
      chk("R4 chunk1 par_b", 32'(par_b[1]), 32'(r1[21:11]));
      chk("R3 code1", 32'(code[1]), 32'(r1));
      chk("R9 two pulses", nd, 2);
      chk("R9 first pulse", d1, 256);
      chk("R9 second pulse", d2, 512);
      for (int i = 0; i < 20; i++) mem[i] = 8'h55;
      feed(20, 0);
      chk("R6 overrun chunk0", 32'(code[0]), 32'(r0));
      chk("R6 overrun chunk1", 32'(code[1]), 32'(r1));
      chk("R6 no pulse", nd, 0);
   endtask

   task automatic t_small_over();
      logic [21:0] r0;
      do_clear(); big_page = 1'b0;
      for (int i = 0; i < 512; i++) mem[i] = 8'(i ^ (i >> 2) ^ 8'h91);
      r0 = ref_pair(0);
      feed(300, 0);
      chk("R5 chunk0", 32'(code[0]), 32'(r0));
      chk("R5 chunk1 zero", 32'(code[1]), 0);
      chk("R5 one pulse", nd, 1);
   endtask

   task automatic t_gaps();
      logic [21:0] r0;
      do_clear(); big_page = 1'b0;
      for (int i = 0; i < 512; i++) mem[i] = 8'(i * 13 + 5);
      r0 = ref_pair(0);
      feed(256, 1);
      chk("R8 gapped chunk0", 32'(code[0]), 32'(r0));
      chk("R8 gapped pulse", d1, 256);
   endtask

   task automatic t_clear();
      logic [21:0] r0;
      big_page = 1'b1;
      for (int i = 0; i < 512; i++) mem[i] = 8'hC3;
      feed(100, 0);
      do_clear();
      chk("R7 clear par_a0", 32'(par_a[0]), 0);
      chk("R7 clear code1", 32'(code[1]), 0);
      big_page = 1'b0;
      for (int i = 0; i < 512; i++) mem[i] = 8'(i + 8'h21);
      r0 = ref_pair(0);
      feed(256, 0);
      chk("R7 counter rewound", 32'(code[0]), 32'(r0));
      chk("R7 pulse after clear", d1, 256);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_erased();
      t_single();
      t_big();
      t_small_over();
      t_gaps();
      t_clear();
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule